// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block sits on the write path of a peripheral's register bus and decides, for every bus write, whether the protected register file may accept it. Software first has to write two 32-bit key words to two key addresses. While that sequence has not been completed, writes to every other address are dropped without any error. Reads never pass through this gate, so the time, status and enable registers can be read at any time without unlocking.

Software unlocks the block by writing the first key and then the second key. It relocks the block by writing zero to either key register. Any other value written to a key register also relocks it. The block leaves reset locked. It has two outputs: a write-enable qualifier, which the register file ANDs into its own write decode, and a lock status for software to read.

Top module: `wp_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `locked_o` is 1 and `wr_en_o` is 0, even with `we_i` high.
- R2: While `locked_o` is 1, `wr_en_o` stays 0 for a write to any address.
- R3: While `locked_o` is 0, `wr_en_o` equals `we_i` in the same cycle for any address that is not a key address.
- R4: Two writes unlock the block: the first writes 0x83E70B13 to address 0x6C, and the next key write puts 0x95A4F1E0 on address 0x70. `locked_o` falls in the cycle after the second write.
- R5: Writing the keys in reverse order, with the second key before the first, leaves the block locked.
- R6: Writes to non-key addresses between the first and second key writes do not break the unlock sequence.
- R7: A write to address 0x6C or 0x70 with any value other than its own key locks the block from the next cycle. If the block was armed by the first key, the arming is lost.
- R8: Writing 0 to a key register while unlocked restores protection from the next cycle.
- R9: A write to a key address never asserts `wr_en_o`.
- R10: A cycle with `we_i` low does not change the lock state, and `wr_en_o` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Bus byte address |
| we_i | input | 1 | Bus write strobe |
| wdata_i | input | 32 | Bus write data |
| wr_en_o | output | 1 | Qualified write enable for the protected register file |
| locked_o | output | 1 | 1 while protected writes are blocked |

## Verification
Two things can happen in the same cycle: the lock state is updated, and a protected write is gated. The bench provokes this in three ways. It issues a protected write in the cycle right after the second key. It issues one right after a relocking zero write. It also places a key write that carries data while the block is unlocked. In each case it judges the write-enable against a behavioural model. That model gates with the state from before the edge and applies the key effect only from the next cycle. Reverse order, interleaved non-key writes and wrong key values are run through the same per-cycle comparison.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    WP_LOCKED   = 2'd0,
    WP_ARMED    = 2'd1,
    WP_UNLOCKED = 2'd2
  } wp_state_e;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4F1E0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        sel_o,
  output logic [1:0]        ok_o
);
  localparam int unsigned NKEYS = 2;
  localparam logic [NKEYS-1:0][ADDR_W-1:0] KADDR = {KEY1_ADDR, KEY0_ADDR};
  localparam logic [NKEYS-1:0][DATA_W-1:0] KVAL  = {KEY1_VAL, KEY0_VAL};

  for (genvar i = 0; i < NKEYS; i++) begin : g_key
    assign sel_o[i] = we_i && (addr_i == KADDR[i]);
    assign ok_o[i]  = sel_o[i] && (wdata_i == KVAL[i]);
  end
endmodule

// File: rtl/wp_lock_fsm.sv
module wp_lock_fsm
  import wp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic [1:0] sel_i,
  input  logic [1:0] ok_i,
  output wp_state_e state_o
);
  wp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (sel_i[0])
      state_d = ok_i[0] ? WP_ARMED : WP_LOCKED;
    else if (sel_i[1])
      state_d = (ok_i[1] && state_q == WP_ARMED) ? WP_UNLOCKED : WP_LOCKED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WP_LOCKED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R4
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WP_UNLOCKED && $past(state_q) != WP_UNLOCKED)
      |-> ($past(ok_i[1]) && $past(state_q) == WP_ARMED));

  // R7
  bad_key_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_i[0] && !ok_i[0]) || (sel_i[1] && !ok_i[1])) |=> state_q == WP_LOCKED);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(state_q));
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4F1E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wr_en_o,
  output logic              locked_o
);
  logic [1:0] key_sel, key_ok;
  wp_state_e  state;

  wp_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
    .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
  ) u_match (
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .sel_o  (key_sel),
    .ok_o   (key_ok)
  );

  wp_lock_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .sel_i  (key_sel),
    .ok_i   (key_ok),
    .state_o(state)
  );

  // key registers live in the gate; never forwarded to the protected file
  assign wr_en_o  = we_i && (key_sel == 2'b00) && (state == WP_UNLOCKED);
  assign locked_o = (state != WP_UNLOCKED);

  // R2
  locked_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !wr_en_o);

  // R9
  key_no_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == KEY0_ADDR || addr_i == KEY1_ADDR)) |-> !wr_en_o);

  // R8
  zero_relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == '0 && (addr_i == KEY0_ADDR || addr_i == KEY1_ADDR)) |=> locked_o);
endmodule

// File: tb/tb_wp_gate.sv
module tb_wp_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = 32'h0;
  logic        wr_en_o, locked_o;

  int checks = 0;
  int fails  = 0;
  int mstate = 0; // 0 locked, 1 first key seen, 2 open
  bit done = 1'b0;

  wp_gate dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .wr_en_o(wr_en_o), .locked_o(locked_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic act_w, input logic exp_w,
                     input logic act_l, input logic exp_l);
    checks++;
    if (act_w !== exp_w || act_l !== exp_l) begin
      fails++;
      $display("FAIL %s: wr_en=%b exp %b locked=%b exp %b", tag, act_w, exp_w, act_l, exp_l);
    end
  endtask

  // one bus cycle: drive after negedge, compare before posedge, then advance model
  task automatic cyc(input string tag, input logic we, input logic [7:0] a, input logic [31:0] d);
    logic is_key, exp_w;
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d;
    #(CLK_PERIOD/4);
    is_key = (a == 8'h6C) || (a == 8'h70);
    exp_w  = we && !is_key && (mstate == 2);
    chk(tag, wr_en_o, exp_w, locked_o, mstate != 2);
    if (we && a == 8'h6C)      mstate = (d == 32'h83E70B13) ? 1 : 0;
    else if (we && a == 8'h70) mstate = (d == 32'h95A4F1E0 && mstate == 1) ? 2 : 0;
  endtask

  task automatic unlock_seq(input string tag);
    cyc(tag, 1'b1, 8'h6C, 32'h83E70B13);
    cyc(tag, 1'b1, 8'h70, 32'h95A4F1E0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 during reset
    we_i = 1'b1; addr_i = 8'h10;
    #(CLK_PERIOD*2 + 1);
    chk("R1 in reset", wr_en_o, 1'b0, locked_o, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc("R1 after reset", 1'b1, 8'h00, 32'h1);

    // R2 locked writes dropped
    cyc("R2", 1'b1, 8'h04, 32'hFFFF);
    cyc("R2", 1'b1, 8'h48, 32'h8);

    // R4 correct sequence, R3 protected write right after
    unlock_seq("R4");
    cyc("R4 R3 first write", 1'b1, 8'h00, 32'h55);
    cyc("R3", 1'b1, 8'hFC, 32'h1);
    // R10 idle keeps state, no write enable
    cyc("R10", 1'b0, 8'h6C, 32'h0);
    cyc("R10", 1'b0, 8'h20, 32'h0);
    cyc("R3 after idle", 1'b1, 8'h20, 32'h7);
    // R9 key address with correct key while open: not forwarded, rearms
    cyc("R9", 1'b1, 8'h6C, 32'h83E70B13);
    cyc("R9 post", 1'b1, 8'h10, 32'h1);

    // R8 zero relock
    unlock_seq("R8 setup");
    cyc("R8", 1'b1, 8'h70, 32'h0);
    cyc("R8 blocked", 1'b1, 8'h04, 32'h3);
    unlock_seq("R8 setup");
    cyc("R8", 1'b1, 8'h6C, 32'h0);
    cyc("R8 blocked", 1'b1, 8'h04, 32'h3);

    // R5 reversed order
    cyc("R5", 1'b1, 8'h70, 32'h95A4F1E0);
    cyc("R5", 1'b1, 8'h6C, 32'h83E70B13);
    cyc("R5 still locked", 1'b1, 8'h08, 32'h1);

    // R6 non-key writes in between
    cyc("R6", 1'b1, 8'h6C, 32'h83E70B13);
    cyc("R6", 1'b1, 8'h00, 32'h9);
    cyc("R6", 1'b0, 8'h70, 32'h0);
    cyc("R6", 1'b1, 8'h44, 32'h2);
    cyc("R6", 1'b1, 8'h70, 32'h95A4F1E0);
    cyc("R6 open", 1'b1, 8'h00, 32'h1);

    // R7 wrong values
    cyc("R7", 1'b1, 8'h70, 32'h95A4F1E1);
    cyc("R7 blocked", 1'b1, 8'h00, 32'h1);
    cyc("R7", 1'b1, 8'h6C, 32'h83E70B13);
    cyc("R7", 1'b1, 8'h6C, 32'h83E70B12);
    cyc("R7", 1'b1, 8'h70, 32'h95A4F1E0);
    cyc("R7 blocked", 1'b1, 8'h00, 32'h1);
    unlock_seq("R7 setup");
    cyc("R7", 1'b1, 8'h6C, 32'h12345678);
    cyc("R7 blocked", 1'b1, 8'h00, 32'h1);

    // R9 second key address while open
    unlock_seq("R9 setup");
    cyc("R9", 1'b1, 8'h70, 32'h95A4F1E0);
    cyc("R9 post", 1'b1, 8'h00, 32'h1);

    // neighbouring addresses are ordinary protected registers
    unlock_seq("R3 setup");
    cyc("R3", 1'b1, 8'h6D, 32'h0);
    cyc("R3", 1'b1, 8'h74, 32'h0);
    cyc("R3", 1'b1, 8'h68, 32'h0);

    @(negedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule